// File: doc/BRIEF.md
# Reset Cause Recording Register

This block is an always-on register that keeps track of why the processor was last reset, so that boot software can read the reason and act on it. A power-on indication sets the power-on cause and wipes every other cause. The power controller supplies a two-bit reset-category code. A strobe marks the cycle in which the processor reset is observed, and on that strobe the block latches each cause that the category permits. Causes are sticky and accumulate until software clears them by writing ones.

After a power-on event the register is muted and ignores further strobes until the processor reset is first released. The hardware request lines can each have their own cause bit, or they can be folded into a single OR-combined bit. A parameter chooses between the two.

Top module: `rst_cause_rec`

## Requirements
- R1: After `rst_ni` is deasserted, `cause_o` reads all zeros and the register is not muted, so a strobe is recorded at once.
- R2: A cycle with `por_i` high leaves `cause_o` with bit 0 (power-on) set and every other bit cleared on the next cycle.
- R3: After `por_i`, strobes are ignored until a cycle with `rel_i` high. A strobe in that same cycle is still ignored. Strobes in later cycles are recorded.
- R4: With category code 0 (no reset triggered), a strobe sets bit 2 if `ndm_req_i` is high. The software and hardware requests are not recorded.
- R5: With category code 1 (low-power entry), a strobe sets bit 1 (low-power exit) and no other bit, whatever the request inputs are.
- R6: With category code 2 (software or peripheral reset), a strobe sets bit 3 if `sw_req_i` is high and sets the hardware bits from `hw_req_i`. The non-debug-module request is not recorded.
- R7: With category code 3, a strobe records nothing.
- R8: Bits are sticky. Several bits can be set by one strobe, new bits add to old ones, and request inputs have no effect without a strobe.
- R9: A write with `clr_we_i` clears exactly those bits where `clr_data_i` is 1. All other bits keep their value.
- R10: If a strobe sets a bit in the same cycle that a write clears it, the bit ends up set.
- R11: With `HW_SPLIT`=1, hardware line i maps to bit 4+i. With `HW_SPLIT`=0, the OR of all hardware lines maps to bit 4.
- R12: `por_i` overrides a strobe and a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low initialisation of the register |
| por_i | input | 1 | Power-on event, one cycle |
| cat_i | input | 2 | Reset category code from the power controller |
| ndm_req_i | input | 1 | Non-debug-module reset request |
| sw_req_i | input | 1 | Software reset request |
| hw_req_i | input | NUM_HW | Hardware peripheral reset requests |
| rec_i | input | 1 | Processor reset observed strobe |
| rel_i | input | 1 | Processor reset release strobe |
| clr_we_i | input | 1 | Write-one-to-clear enable |
| clr_data_i | input | 4+HW bits | Bits to clear |
| cause_o | output | 4+HW bits | Recorded cause bits |

## Verification
Every result passes through exactly one register. A strobe, a clear or a power-on event presented in one cycle therefore shows on `cause_o` after the next rising edge. The mute flag follows the same rule, so a release takes effect for strobes one cycle later. The bench drives inputs on the falling edge and checks on the following falling edge, which is exactly one rising edge later. A second instance with folded hardware bits receives the same stimulus so that both variants are compared.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
   typedef enum logic [1:0] {
      CAT_NONE   = 2'd0,
      CAT_LOWPWR = 2'd1,
      CAT_REQ    = 2'd2,
      CAT_RSVD   = 2'd3
   } rst_cat_e;

   localparam int unsigned BIT_POR = 0;
   localparam int unsigned BIT_LPE = 1;
   localparam int unsigned BIT_NDM = 2;
   localparam int unsigned BIT_SW  = 3;
   localparam int unsigned BIT_HW0 = 4;

   function automatic int unsigned hw_width(int unsigned n, bit split);
      return split ? n : 1;
   endfunction
endpackage

// File: rtl/rcr_hw_fold.sv
module rcr_hw_fold #(
   parameter int unsigned NUM_HW   = 3,
   parameter bit          HW_SPLIT = 1'b1,
   localparam int unsigned HWB     = rcr_pkg::hw_width(NUM_HW, HW_SPLIT)
) (
   input  logic [NUM_HW-1:0] req_i,
   output logic [HWB-1:0]    bits_o
);
   generate
      if (HW_SPLIT) begin : g_split
         assign bits_o = req_i;
      end else begin : g_fold
         assign bits_o = |req_i;
      end
   endgenerate
endmodule

// File: rtl/rcr_authorize.sv
module rcr_authorize #(
   parameter int unsigned HWB = 3,
   localparam int unsigned W  = rcr_pkg::BIT_HW0 + HWB
) (
   input  logic [1:0]     cat_i,
   input  logic           ndm_i,
   input  logic           sw_i,
   input  logic [HWB-1:0] hw_i,
   output logic [W-1:0]   set_o
);
   import rcr_pkg::*;
   rst_cat_e cat;
   assign cat = rst_cat_e'(cat_i);

   always_comb begin
      set_o = '0;
      unique case (cat)
         CAT_NONE:   set_o[BIT_NDM] = ndm_i;
         CAT_LOWPWR: set_o[BIT_LPE] = 1'b1;
         CAT_REQ: begin
            set_o[BIT_SW]            = sw_i;
            set_o[W-1:BIT_HW0]       = hw_i;
         end
         default:    set_o = '0;
      endcase
   end
endmodule

// File: rtl/rcr_store.sv
module rcr_store #(
   parameter int unsigned W = 7
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         por_i,
   input  logic         rec_i,
   input  logic         rel_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] clr_data_i,
   input  logic [W-1:0] set_i,
   output logic [W-1:0] cause_o,
   output logic         muted_o
);
   localparam logic [W-1:0] POR_ONLY = {{(W-1){1'b0}}, 1'b1};

   logic [W-1:0] cause_q;
   logic         mute_q;
   logic [W-1:0] clr_mask, set_mask;

   assign clr_mask = clr_we_i ? clr_data_i : '0;
   assign set_mask = (rec_i && !mute_q) ? set_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cause_q <= '0;
         mute_q  <= 1'b0;
      end else if (por_i) begin
         cause_q <= POR_ONLY;
         mute_q  <= 1'b1;
      end else begin
         cause_q <= (cause_q & ~clr_mask) | set_mask;
         if (rel_i) mute_q <= 1'b0;
      end
   end

   assign cause_o = cause_q;
   assign muted_o = mute_q;
endmodule

// File: rtl/rst_cause_rec.sv
module rst_cause_rec #(
   parameter int unsigned NUM_HW   = 3,
   parameter bit          HW_SPLIT = 1'b1,
   localparam int unsigned HWB     = rcr_pkg::hw_width(NUM_HW, HW_SPLIT),
   localparam int unsigned W       = rcr_pkg::BIT_HW0 + HWB
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              por_i,
   input  logic [1:0]        cat_i,
   input  logic              ndm_req_i,
   input  logic              sw_req_i,
   input  logic [NUM_HW-1:0] hw_req_i,
   input  logic              rec_i,
   input  logic              rel_i,
   input  logic              clr_we_i,
   input  logic [W-1:0]      clr_data_i,
   output logic [W-1:0]      cause_o
);
   generate
      if (NUM_HW < 1) begin : g_bad_num_hw
         $error("NUM_HW must be at least 1");
      end
   endgenerate

   logic [HWB-1:0] hw_bits;
   logic [W-1:0]   set_vec;
   logic           muted;

   rcr_hw_fold #(.NUM_HW(NUM_HW), .HW_SPLIT(HW_SPLIT)) u_fold (
      .req_i  (hw_req_i),
      .bits_o (hw_bits)
   );

   rcr_authorize #(.HWB(HWB)) u_auth (
      .cat_i (cat_i),
      .ndm_i (ndm_req_i),
      .sw_i  (sw_req_i),
      .hw_i  (hw_bits),
      .set_o (set_vec)
   );

   rcr_store #(.W(W)) u_store (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .por_i      (por_i),
      .rec_i      (rec_i),
      .rel_i      (rel_i),
      .clr_we_i   (clr_we_i),
      .clr_data_i (clr_data_i),
      .set_i      (set_vec),
      .cause_o    (cause_o),
      .muted_o    (muted)
   );
endmodule

// File: rtl/rcr_chk.sv
module rcr_chk #(
   parameter int unsigned W = 7
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         por_i,
   input logic [1:0]   cat_i,
   input logic         rec_i,
   input logic         rel_i,
   input logic         clr_we_i,
   input logic [W-1:0] clr_data_i,
   input logic [W-1:0] cause_o,
   input logic         muted_i
);
   localparam logic [W-1:0] POR_ONLY = {{(W-1){1'b0}}, 1'b1};

   assert_por_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      por_i |=> (cause_o == POR_ONLY));

   assert_por_mutes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      por_i |=> muted_i);

   assert_muted_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (muted_i && !por_i && !clr_we_i) |=> $stable(cause_o));

   assert_ndm_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cause_o[2]) |-> ($past(cat_i) == 2'd0 && $past(rec_i)));

   assert_lpe_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cause_o[1]) |-> ($past(cat_i) == 2'd1 && $past(rec_i)));

   assert_no_set_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rec_i && !por_i) |=> ((cause_o & ~$past(cause_o)) == '0));

   assert_w1c_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && !rec_i && !por_i) |=> ((cause_o & $past(clr_data_i)) == '0));

   assert_unmute_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rel_i && !por_i) |=> !muted_i);
endmodule

bind rst_cause_rec rcr_chk #(.W(W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .por_i      (por_i),
   .cat_i      (cat_i),
   .rec_i      (rec_i),
   .rel_i      (rel_i),
   .clr_we_i   (clr_we_i),
   .clr_data_i (clr_data_i),
   .cause_o    (cause_o),
   .muted_i    (muted)
);

// File: tb/rst_cause_rec_tb.sv
module rst_cause_rec_tb;
   localparam int unsigned NHW = 3;
   localparam int unsigned W   = 4 + NHW;
   localparam int unsigned WO  = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           por = 1'b0;
   logic [1:0]     cat = 2'd0;
   logic           ndm = 1'b0, sw = 1'b0;
   logic [NHW-1:0] hw = '0;
   logic           rec = 1'b0, rel = 1'b0, clr_we = 1'b0;
   logic [W-1:0]   clr_data = '0;
   logic [W-1:0]   cause;
   logic [WO-1:0]  cause_or;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4ns clk = ~clk;

   rst_cause_rec #(.NUM_HW(NHW), .HW_SPLIT(1'b1)) u_dut (
      .clk_i(clk), .rst_ni(rst_n), .por_i(por), .cat_i(cat),
      .ndm_req_i(ndm), .sw_req_i(sw), .hw_req_i(hw),
      .rec_i(rec), .rel_i(rel), .clr_we_i(clr_we),
      .clr_data_i(clr_data), .cause_o(cause));

   rst_cause_rec #(.NUM_HW(NHW), .HW_SPLIT(1'b0)) u_dut_or (
      .clk_i(clk), .rst_ni(rst_n), .por_i(por), .cat_i(cat),
      .ndm_req_i(ndm), .sw_req_i(sw), .hw_req_i(hw),
      .rec_i(rec), .rel_i(rel), .clr_we_i(clr_we),
      .clr_data_i(clr_data[WO-1:0]), .cause_o(cause_or));

   task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", req, got, exp);
      end
   endtask

   task automatic idle();
      por = 1'b0; rec = 1'b0; rel = 1'b0; clr_we = 1'b0; clr_data = '0;
      ndm = 1'b0; sw = 1'b0; hw = '0; cat = 2'd0;
   endtask

   // apply current inputs for one rising edge, then return at the falling edge
   task automatic cycle();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      chk("R1 reset", cause, '0);
      chk("R1 reset or", W'(cause_or), '0);
   endtask

   task automatic t_cat_req();
      cat = 2'd2; sw = 1'b1; ndm = 1'b1; hw = 3'b101; rec = 1'b1;
      cycle();
      chk("R6 req category", cause, 7'b1011000);
      chk("R11 folded hw", W'(cause_or), 7'b0011000);
      clr_we = 1'b1; clr_data = '1;
      cycle();
      chk("R9 clear all", cause, '0);
   endtask

   task automatic t_hw_fold();
      cat = 2'd2; hw = 3'b010; rec = 1'b1;
      cycle();
      chk("R11 split line 1 -> bit5", cause, 7'b0100000);
      chk("R11 or bit4", W'(cause_or), 7'b0010000);
      clr_we = 1'b1; clr_data = '1;
      cycle();
   endtask

   task automatic t_cat_none();
      cat = 2'd0; ndm = 1'b1; sw = 1'b1; hw = '1; rec = 1'b1;
      cycle();
      chk("R4 none category", cause, 7'b0000100);
   endtask

   task automatic t_lowpwr();
      cat = 2'd1; ndm = 1'b1; sw = 1'b1; hw = '1; rec = 1'b1;
      cycle();
      chk("R5 lowpower plus R8 sticky", cause, 7'b0000110);
   endtask

   task automatic t_rsvd();
      cat = 2'd3; ndm = 1'b1; sw = 1'b1; hw = '1; rec = 1'b1;
      cycle();
      chk("R7 reserved code", cause, 7'b0000110);
   endtask

   task automatic t_no_strobe();
      cat = 2'd2; sw = 1'b1; hw = '1;
      cycle();
      chk("R8 no strobe", cause, 7'b0000110);
   endtask

   task automatic t_w1c();
      clr_we = 1'b1; clr_data = 7'b0000010;
      cycle();
      chk("R9 clear one bit", cause, 7'b0000100);
      clr_we = 1'b1; clr_data = 7'b1111001;
      cycle();
      chk("R9 ones on clear bits", cause, 7'b0000100);
   endtask

   task automatic t_set_over_clr();
      cat = 2'd0; ndm = 1'b1; rec = 1'b1; clr_we = 1'b1; clr_data = 7'b0000100;
      cycle();
      chk("R10 set beats clear", cause, 7'b0000100);
   endtask

   task automatic t_por();
      por = 1'b1; cat = 2'd2; sw = 1'b1; rec = 1'b1;
      clr_we = 1'b1; clr_data = 7'b0000001;
      cycle();
      chk("R2 R12 por result", cause, 7'b0000001);
      chk("R2 por or", W'(cause_or), 7'b0000001);
   endtask

   task automatic t_mute();
      cat = 2'd2; sw = 1'b1; rec = 1'b1;
      cycle();
      chk("R3 muted strobe", cause, 7'b0000001);
      cat = 2'd2; sw = 1'b1; rec = 1'b1; rel = 1'b1;
      cycle();
      chk("R3 release same cycle", cause, 7'b0000001);
      cat = 2'd2; sw = 1'b1; rec = 1'b1;
      cycle();
      chk("R3 after release", cause, 7'b0001001);
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cat_req();
      t_hw_fold();
      t_cat_none();
      t_lowpwr();
      t_rsvd();
      t_no_strobe();
      t_w1c();
      t_set_over_clr();
      t_por();
      t_mute();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule